// File: doc/BRIEF.md
# DDR Command Sequencer Front-End

This block sits between a simple requester and a DDR command bus. The requester presents one abstract request at a time: a read, a write or a refresh, with a 16-bit linear address and a 128-bit burst of write data. The block expands each request into the DDR-style command sequence that the memory needs, on a decoded command bus. A read or write opens the row with ACTIVATE, waits out the row-to-column delay, issues the column READ or WRITE, waits for the transfer to finish, then closes the row with PRECHARGE and waits out the precharge delay. A refresh issues REFRESH and then holds the bus idle for the refresh recovery time.

A two-valued status output tells the requester when it may present the next request. The requester needs no knowledge of rows, columns, bank timing, on-die termination or data-bus direction. The block handles all of these. It assumes that the requester and the sequencer run on phase-aligned clocks. PHY timing, strobe capture and power-up initialisation are handled elsewhere.

Top module: `ddr_cmd_frontend`

## Requirements
- R1: `req_status` reads 1 (ready) whenever the block is idle and 2 (busy) from the cycle after a request is accepted until the sequence ends. A request is accepted only at a clock edge where `req_status` is 1 and `req_valid` is 1. Requests that arrive while the status is 2 have no effect.
- R2: A read or write produces, on `ddr_cmd`, ACTIVATE (code 1), then TRCD cycles of NOP, then the column command (READ code 2 or WRITE code 3), then TDONE cycles of NOP, then PRECHARGE (code 4), then TRP cycles of NOP, after which the block is ready again. A read inserts one extra NOP cycle between the completion wait and PRECHARGE. The default timing is TRCD=3, TDONE=6 and TRP=3.
- R3: The request address splits into a row and a column. Bits 15:10 form the row, which appears on `ddr_addr[5:0]` with ACTIVATE and with PRECHARGE, with the upper bits zero. Bits 9:0 form the column, which appears on `ddr_addr` with the column command.
- R4: On accepting a read or write, the block latches the write data, the column and the direction. The latched data appears on `wr_burst` from the next cycle on. A refresh request or an ignored request leaves `wr_burst` unchanged.
- R5: `dq_drive` takes the request's direction in the cycle after ACTIVATE: 1 for a write and 0 for a read. It keeps that value until PRECHARGE, when it returns to 0.
- R6: `odt_en` is 1 for exactly the one cycle after a WRITE column command and is 0 in every other cycle, including the whole of every read.
- R7: A refresh request ignores the address and data. It produces REFRESH (code 5, address 0) followed by TRFC=14 cycles of NOP, after which the block is ready again.
- R8: For a read, `rd_valid` pulses for one cycle, in the cycle just before PRECHARGE. In that cycle `rd_burst` equals the value that `rd_burst_in` carried during the last completion-wait cycle.
- R9: In every cycle that does not issue a command, `ddr_cmd` is NOP (code 0) and `ddr_addr` is 0.
- R10: An active-high synchronous reset returns the block to ready, with NOP on the command bus, `odt_en` at 0, `dq_drive` at 0, `rd_valid` at 0 and `wr_burst` cleared. A reset that arrives in the middle of a sequence abandons that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_refresh | input | 1 | 1 = refresh request (address and data ignored) |
| req_addr | input | 16 | Linear address: row in 15:10, column in 9:0 |
| req_wdata | input | 128 | Write burst, eight 16-bit beats |
| req_status | output | 2 | 1 = ready, 2 = busy |
| ddr_cmd | output | 3 | Decoded command: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH |
| ddr_addr | output | 10 | Row or column address for the current command |
| dq_drive | output | 1 | Data-bus drive enable (0 = all lanes released) |
| odt_en | output | 1 | On-die termination enable |
| wr_burst | output | 128 | Latched write burst |
| rd_burst_in | input | 128 | Captured read burst from the PHY |
| rd_valid | output | 1 | One-cycle read-return strobe |
| rd_burst | output | 128 | Returned read burst |

## Verification
The bench goes after requests that arrive while the block is busy, including a held strobe that spans the end of one sequence. A design that failed to gate them would start a second ACTIVATE early or overwrite `wr_burst`. The bench also tests a refresh that carries junk address and data, which would corrupt the latched write burst if the block did not ignore them. It checks the one-cycle placement of ODT and of the read-return strobe: an off-by-one in either would show up as a mismatch against the cycle-by-cycle model. Further checks cover row and column values at their extremes, which would catch a wrong bit split or a missing zero-extension. A reset in the middle of a write must leave the bus released and the block ready.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } ddr_cmd_e;

  localparam logic [1:0] STAT_READY = 2'd1;
  localparam logic [1:0] STAT_BUSY  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACT,
    S_RCD,
    S_COL,
    S_DONE,
    S_RET,
    S_PRE,
    S_RP,
    S_REF,
    S_RFC
  } seq_state_e;

endpackage

// File: rtl/ddrseq_wait_timer.sv
module ddrseq_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ddrseq_req_latch.sv
module ddrseq_req_latch #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 10,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_data,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              is_write,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      row      <= '0;
      col      <= '0;
      is_write <= 1'b0;
      data     <= '0;
    end else if (capture) begin
      row      <= in_row;
      col      <= in_col;
      is_write <= in_write;
      data     <= in_data;
    end
  end

endmodule

// File: rtl/ddrseq_rdata_reg.sv
module ddrseq_rdata_reg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) dout <= din;
    end
  end

endmodule

// File: rtl/ddr_cmd_frontend.sv
module ddr_cmd_frontend
  import ddrseq_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 10,
  parameter int DATA_W = 128,
  parameter int TRCD   = 3,
  parameter int TDONE  = 6,
  parameter int TRP    = 3,
  parameter int TRFC   = 14
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       req_valid,
  input  logic                                       req_write,
  input  logic                                       req_refresh,
  input  logic [ROW_W+COL_W-1:0]                     req_addr,
  input  logic [DATA_W-1:0]                          req_wdata,
  output logic [1:0]                                 req_status,
  output logic [2:0]                                 ddr_cmd,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ddr_addr,
  output logic                                       dq_drive,
  output logic                                       odt_en,
  output logic [DATA_W-1:0]                          wr_burst,
  input  logic [DATA_W-1:0]                          rd_burst_in,
  output logic                                       rd_valid,
  output logic [DATA_W-1:0]                          rd_burst
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MAX_A  = (TRCD > TDONE) ? TRCD : TDONE;
  localparam int MAX_B  = (TRP > TRFC) ? TRP : TRFC;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_W + 1);

  seq_state_e state, state_n;

  logic             accept;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;

  logic [ROW_W-1:0] req_row, lat_row;
  logic [COL_W-1:0] req_col, lat_col;
  logic             lat_write;
  logic [CA_W-1:0]  req_row_x, lat_row_x, lat_col_x;

  assign req_row = req_addr[ADDR_W-1 -: ROW_W];
  assign req_col = req_addr[COL_W-1:0];
  assign accept  = (state == S_IDLE) && req_valid;

  // Zero-extend row and column onto the shared command address bus.
  generate
    if (CA_W > ROW_W) begin : g_row_pad
      assign req_row_x = {{(CA_W-ROW_W){1'b0}}, req_row};
      assign lat_row_x = {{(CA_W-ROW_W){1'b0}}, lat_row};
    end else begin : g_row_full
      assign req_row_x = req_row;
      assign lat_row_x = lat_row;
    end
    if (CA_W > COL_W) begin : g_col_pad
      assign lat_col_x = {{(CA_W-COL_W){1'b0}}, lat_col};
    end else begin : g_col_full
      assign lat_col_x = lat_col;
    end
  endgenerate

  ddrseq_req_latch #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (accept && !req_refresh),
    .in_row  (req_row),
    .in_col  (req_col),
    .in_write(req_write),
    .in_data (req_wdata),
    .row     (lat_row),
    .col     (lat_col),
    .is_write(lat_write),
    .data    (wr_burst)
  );

  ddrseq_wait_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .expired (t_expired)
  );

  ddrseq_rdata_reg #(
    .DATA_W(DATA_W)
  ) u_rdata (
    .clk    (clk),
    .rst    (rst),
    .capture(state_n == S_RET),
    .din    (rd_burst_in),
    .dout   (rd_burst),
    .valid  (rd_valid)
  );

  // Next-state logic; every wait state is entered with the timer loaded.
  always_comb begin
    state_n = state;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state)
      S_IDLE: if (req_valid) state_n = req_refresh ? S_REF : S_ACT;
      S_ACT: begin
        state_n = S_RCD;
        t_load  = 1'b1;
        t_val   = CNT_W'(TRCD - 1);
      end
      S_RCD:  if (t_expired) state_n = S_COL;
      S_COL: begin
        state_n = S_DONE;
        t_load  = 1'b1;
        t_val   = CNT_W'(TDONE - 1);
      end
      S_DONE: if (t_expired) state_n = lat_write ? S_PRE : S_RET;
      S_RET:  state_n = S_PRE;
      S_PRE: begin
        state_n = S_RP;
        t_load  = 1'b1;
        t_val   = CNT_W'(TRP - 1);
      end
      S_RP:   if (t_expired) state_n = S_IDLE;
      S_REF: begin
        state_n = S_RFC;
        t_load  = 1'b1;
        t_val   = CNT_W'(TRFC - 1);
      end
      S_RFC:  if (t_expired) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  // Registered outputs decoded from the state being entered.
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      req_status <= STAT_READY;
      ddr_cmd    <= CMD_NOP;
      ddr_addr   <= '0;
      dq_drive   <= 1'b0;
      odt_en     <= 1'b0;
    end else begin
      state      <= state_n;
      req_status <= (state_n == S_IDLE) ? STAT_READY : STAT_BUSY;
      odt_en     <= (state == S_COL) && lat_write;
      if (state == S_ACT) begin
        dq_drive <= lat_write;
      end else if (state_n == S_PRE) begin
        dq_drive <= 1'b0;
      end
      unique case (state_n)
        S_ACT: begin
          ddr_cmd  <= CMD_ACT;
          ddr_addr <= req_row_x;
        end
        S_COL: begin
          ddr_cmd  <= lat_write ? CMD_WR : CMD_RD;
          ddr_addr <= lat_col_x;
        end
        S_PRE: begin
          ddr_cmd  <= CMD_PRE;
          ddr_addr <= lat_row_x;
        end
        S_REF: begin
          ddr_cmd  <= CMD_REF;
          ddr_addr <= '0;
        end
        default: begin
          ddr_cmd  <= CMD_NOP;
          ddr_addr <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ddrseq_checks.sv
module ddrseq_checks
  import ddrseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_status,
  input logic [2:0] ddr_cmd,
  input logic       dq_drive,
  input logic       odt_en,
  input logic       rd_valid
);

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_status == STAT_READY && req_valid) |=> (req_status == STAT_BUSY)); // R1

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    (req_status == STAT_READY) || (req_status == STAT_BUSY)); // R1

  AST_OPEN_FROM_READY: assert property (@(posedge clk) disable iff (rst)
    (ddr_cmd == CMD_ACT || ddr_cmd == CMD_REF) |-> ($past(req_status) == STAT_READY)); // R2

  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ddr_cmd != CMD_NOP) |-> (req_status == STAT_BUSY)); // R9

  AST_WR_THEN_ODT: assert property (@(posedge clk) disable iff (rst)
    (ddr_cmd == CMD_WR) |=> odt_en); // R6

  AST_ODT_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    odt_en |-> ($past(ddr_cmd) == CMD_WR)); // R6

  AST_ODT_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
    odt_en |-> dq_drive); // R5

  AST_PRE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    (ddr_cmd == CMD_PRE) |-> !dq_drive); // R5

  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R8

  AST_RDV_BEFORE_PRE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (ddr_cmd == CMD_PRE)); // R8

endmodule

bind ddr_cmd_frontend ddrseq_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_status(req_status),
  .ddr_cmd   (ddr_cmd),
  .dq_drive  (dq_drive),
  .odt_en    (odt_en),
  .rd_valid  (rd_valid)
);

// File: tb/tb_ddr_cmd_frontend.sv
module tb_ddr_cmd_frontend;

  localparam int TRCD  = 3;
  localparam int TDONE = 6;
  localparam int TRP   = 3;
  localparam int TRFC  = 14;
  localparam int LIMIT = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic         req_refresh = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [1:0]   req_status;
  logic [2:0]   ddr_cmd;
  logic [9:0]   ddr_addr;
  logic         dq_drive;
  logic         odt_en;
  logic [127:0] wr_burst;
  logic [127:0] rd_burst_in = '0;
  logic         rd_valid;
  logic [127:0] rd_burst;

  always #10 clk = ~clk;

  ddr_cmd_frontend #(
    .TRCD(TRCD), .TDONE(TDONE), .TRP(TRP), .TRFC(TRFC)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_refresh(req_refresh), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_status(req_status), .ddr_cmd(ddr_cmd), .ddr_addr(ddr_addr),
    .dq_drive(dq_drive), .odt_en(odt_en), .wr_burst(wr_burst),
    .rd_burst_in(rd_burst_in), .rd_valid(rd_valid), .rd_burst(rd_burst)
  );

  typedef struct {
    int           cmd;
    int           addr;
    int           st;
    int           odt;
    int           oe;
    int           rdv;
    logic [127:0] rd;
    string        tag;
  } exp_t;

  exp_t         q[$];
  int           cyc = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           prev_idle = 1'b0;
  logic [127:0] exp_wdata = '0;

  function automatic logic [127:0] pat(int m);
    logic [31:0] v = 32'(m);
    return {v * 32'h9E3779B1, v ^ 32'h5A5A0F0F, ~v, v + 32'h01234567};
  endfunction

  function automatic exp_t mk(int cmd, int addr, int odt, int oe, int rdv,
                              logic [127:0] rd, string tag);
    exp_t e;
    e.cmd = cmd; e.addr = addr; e.st = 2; e.odt = odt; e.oe = oe;
    e.rdv = rdv; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  // Behavioural model: the accepted request expands into a list of per-cycle expectations.
  task automatic push_seq(bit wr, bit rf, logic [15:0] a);
    int row = int'(a[15:10]);
    int col = int'(a[9:0]);
    if (rf) begin
      q.push_back(mk(5, 0, 0, 0, 0, '0, "R7"));
      for (int i = 0; i < TRFC; i++) q.push_back(mk(0, 0, 0, 0, 0, '0, "R7"));
    end else begin
      q.push_back(mk(1, row, 0, 0, 0, '0, "R3"));
      for (int i = 0; i < TRCD; i++) q.push_back(mk(0, 0, 0, int'(wr), 0, '0, "R2"));
      q.push_back(mk(wr ? 3 : 2, col, 0, int'(wr), 0, '0, "R3"));
      for (int i = 0; i < TDONE; i++)
        q.push_back(mk(0, 0, (i == 0 && wr) ? 1 : 0, int'(wr), 0, '0, "R2"));
      if (!wr) q.push_back(mk(0, 0, 0, 0, 1, pat(cyc + 1 + TRCD + TDONE), "R8"));
      q.push_back(mk(4, row, 0, 0, 0, '0, "R3"));
      for (int i = 0; i < TRP; i++) q.push_back(mk(0, 0, 0, 0, 0, '0, "R2"));
    end
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      finish_run();
    end
    if (rst) begin
      q.delete();
      exp_wdata = '0;
    end else if (prev_idle && req_valid) begin
      push_seq(req_write, req_refresh, req_addr);
      if (!req_refresh) exp_wdata = req_wdata;
    end
    rd_burst_in = pat(cyc);
    if (q.size() == 0) begin
      e = mk(0, 0, 0, 0, 0, '0, rst ? "R10" : "R9");
      e.st = 1;
      prev_idle = 1'b1;
    end else begin
      e = q.pop_front();
      prev_idle = 1'b0;
    end
    chk(e.tag, "cmd", 128'(ddr_cmd), 128'(e.cmd));
    chk(e.tag, "addr", 128'(ddr_addr), 128'(e.addr));
    chk(rst ? "R10" : "R1", "status", 128'(req_status), 128'(e.st));
    chk(rst ? "R10" : "R6", "odt", 128'(odt_en), 128'(e.odt));
    chk(rst ? "R10" : "R5", "dq_drive", 128'(dq_drive), 128'(e.oe));
    chk(rst ? "R10" : "R8", "rd_valid", 128'(rd_valid), 128'(e.rdv));
    if (e.rdv != 0) chk("R8", "rd_burst", rd_burst, e.rd);
    chk(rst ? "R10" : "R4", "wr_burst", wr_burst, exp_wdata);
  endtask

  task automatic wait_idle();
    while (!prev_idle) step();
  endtask

  task automatic issue(bit wr, bit rf, logic [15:0] a, logic [127:0] d);
    wait_idle();
    req_valid = 1'b1; req_write = wr; req_refresh = rf; req_addr = a; req_wdata = d;
    step();
    req_valid = 1'b0;
    step();
  endtask

  initial begin
    // R10: reset state
    repeat (3) step();
    rst = 1'b0;
    repeat (2) step();

    // R2 R3 R4 R5 R6: write with mixed address bits
    issue(1'b1, 1'b0, 16'hA5F3, {8{16'hC0DE}});
    wait_idle();
    // R8: read
    issue(1'b0, 1'b0, 16'h0401, {8{16'h1111}});
    wait_idle();
    // R7 R4: refresh with junk address and data leaves wr_burst alone
    issue(1'b0, 1'b1, 16'hFFFF, {8{16'hDEAD}});
    wait_idle();

    // R1: requests while busy are ignored
    issue(1'b1, 1'b0, 16'h7C00, {8{16'h2468}});
    repeat (3) step();
    req_valid = 1'b1; req_write = 1'b0; req_refresh = 1'b1;
    req_addr = 16'h1234; req_wdata = {8{16'hBAD0}};
    repeat (4) step();
    req_valid = 1'b0;
    wait_idle();

    // R1: strobe held across two back-to-back writes
    req_valid = 1'b1; req_write = 1'b1; req_refresh = 1'b0;
    req_addr = 16'h03FF; req_wdata = {8{16'h5A5A}};
    step(); step();
    req_addr = 16'hFC00; req_wdata = {8{16'hA5A5}};
    wait_idle();
    step();
    req_valid = 1'b0;
    wait_idle();

    // R3 R8: read at the extreme row and column
    issue(1'b0, 1'b0, 16'hFFFF, '0);
    wait_idle();
    issue(1'b0, 1'b0, 16'h0000, '0);
    wait_idle();

    // R10: reset in the middle of a write
    issue(1'b1, 1'b0, 16'h8421, {8{16'h0F0F}});
    repeat (5) step();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    repeat (2) step();

    // R7 then R2: refresh followed by a final write
    issue(1'b0, 1'b1, 16'h0000, '0);
    issue(1'b1, 1'b0, 16'h2C2C, {8{16'h7777}});
    wait_idle();
    repeat (3) step();
    finish_run();
  end

endmodule